// File: doc/BRIEF.md
# EPROM Byte-Programming Retry Sequencer

This block writes a complete image into a byte-wide one-time-erasable memory array, one address at a time. It fetches each source byte through a small request/acknowledge port and then reads the target cell with the programming voltage raised. A byte that already holds the wanted value is skipped. A byte that would need a bit raised from 0 to 1 is impossible, because only an erase can do that, so the run stops at once. Every other byte is programmed by a loop of timed chip-enable pulses, each followed by a verify read. The attempt count restarts at zero for each address and is capped.

When the last address has verified, the block lowers the programming-voltage select and lets it settle. It then reads every byte back in normal read mode and compares it against a second fetch of the source data. `done` rises and stays high, and `pass` reports the outcome. After a failure, `romAddr` keeps the address that failed. All durations are parameters counted in clock cycles. The defaults assume a 125 MHz clock: 2 µs setup and hold, a 100 µs pulse, a 150 ns read and a 130 ns float, with 25 attempts and a 15-bit address. The block only selects the voltage level. It does not generate it.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset the block is idle with busy, done, srcReq, romDoutEn and vppHigh low and romCeN, romOeN high.
- R2: For each fetch, srcReq stays high with srcAddr equal to romAddr until srcAck. The byte on srcData in the srcAck cycle is the one later driven on romDout.
- R3: If the pre-check read at an address shows a 0 in a bit where the target is 1, the run ends with pass=0 and no pulse at that address, and romAddr holds that address.
- R4: If the pre-check read already equals the target, the address receives no pulse.
- R5: Each pulse happens with vppHigh=1 and romOeN=1. romDoutEn rises SETUP_CYC cycles before romCeN falls. romCeN stays low for exactly PULSE_CYC cycles. romDoutEn falls HOLD_CYC cycles after romCeN rises.
- R6: romDoutEn is never high while romOeN is low. After each pulse a verify read follows, with romCeN high, romOeN low and vppHigh=1.
- R7: A verify mismatch triggers another pulse. The attempt count restarts at each address, so a byte that needs N ≤ MAX_PULSES pulses receives exactly N.
- R8: After MAX_PULSES pulses at an address without a match, the run ends with pass=0, romAddr at that address and no further pulse.
- R9: After the last address, vppHigh drops and each byte is read once with romCeN and romOeN low. No write pulse (romCeN low with romOeN high) occurs in this phase.
- R10: A read-back mismatch ends the run with pass=0 and romAddr at the first mismatching address.
- R11: done stays high until the next start, and pass=1 only when every byte has verified. start has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle or done |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished; held until next start |
| pass | output | 1 | Result of the finished run |
| srcReq | output | 1 | Source byte request |
| srcAddr | output | ADDR_W | Address of requested source byte |
| srcAck | input | 1 | Source byte valid on srcData |
| srcData | input | DATA_W | Source byte |
| romAddr | output | ADDR_W | Memory address |
| romDout | output | DATA_W | Data to program |
| romDoutEn | output | 1 | Drive enable for romDout |
| romDin | input | DATA_W | Data read from the memory |
| romCeN | output | 1 | Chip enable, active low |
| romOeN | output | 1 | Output enable, active low |
| vppHigh | output | 1 | Select the programming-voltage level |

## Verification
The bench models cells that each need a set number of pulses before they take the data. It drives one byte to exactly the attempt limit, where a design with an off-by-one limit would fail it, and one byte past the limit, where a design with no cap would keep pulsing. It also gives one byte an impossible 0-to-1 change, where a design without the pre-check would pulse uselessly and exhaust its attempts. A cell that reads differently at normal voltage shows whether the final read-back really compares data and stops at the right address. Erased target bytes show whether the sequencer skips them. A start issued mid-run reveals a sequencer that restarts, because the source fetch count grows.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;
  typedef enum logic [2:0] {TM_SETUP, TM_PULSE, TM_HOLD, TM_READ, TM_FLOAT} tmrSel_e;

  typedef struct packed {
    logic    addrClr;
    logic    addrInc;
    logic    attClr;
    logic    attInc;
    logic    tgtLoad;
    logic    rdCap;
    logic    tmrLoad;
    tmrSel_e tmrSel;
  } ctrlStrobe_t;

  typedef struct packed {
    logic tmrZero;
    logic lastAddr;
    logic attMax;
    logic rdEq;
    logic rdBad;
  } dpStatus_t;
endpackage

// File: rtl/eprom_prog_dp.sv
module eprom_prog_dp
  import eprom_prog_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 250,
  parameter int PULSE_CYC  = 12500,
  parameter int HOLD_CYC   = 250,
  parameter int READ_CYC   = 19,
  parameter int FLOAT_CYC  = 17,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  output dpStatus_t         sts,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] tgt,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] romDin
);
  localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_B   = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
  localparam int MAX_C   = (MAX_B > FLOAT_CYC) ? MAX_B : FLOAT_CYC;
  localparam int TMR_MAX = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int ATT_W   = $clog2(MAX_PULSES + 1);

  logic [TMR_W-1:0]  tmr, tmrInit;
  logic [ATT_W-1:0]  attCnt;
  logic [DATA_W-1:0] rdReg;

  always_comb begin
    case (stb.tmrSel)
      TM_SETUP: tmrInit = TMR_W'(SETUP_CYC - 1);
      TM_PULSE: tmrInit = TMR_W'(PULSE_CYC - 1);
      TM_HOLD:  tmrInit = TMR_W'(HOLD_CYC - 1);
      TM_READ:  tmrInit = TMR_W'(READ_CYC - 1);
      default:  tmrInit = TMR_W'(FLOAT_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr    <= '0;
      attCnt <= '0;
      addr   <= '0;
      tgt    <= '0;
      rdReg  <= '0;
    end else begin
      if (stb.tmrLoad)    tmr <= tmrInit;
      else if (tmr != 0)  tmr <= tmr - 1'b1;
      if (stb.attClr)      attCnt <= '0;
      else if (stb.attInc) attCnt <= attCnt + 1'b1;
      if (stb.addrClr)      addr <= '0;
      else if (stb.addrInc) addr <= addr + 1'b1;
      if (stb.tgtLoad) tgt   <= srcData;
      if (stb.rdCap)   rdReg <= romDin;
    end
  end

  always_comb begin
    sts.tmrZero  = (tmr == 0);
    sts.lastAddr = (addr == {ADDR_W{1'b1}});
    sts.attMax   = (attCnt == ATT_W'(MAX_PULSES));
    sts.rdEq     = (rdReg == tgt);
    sts.rdBad    = |(~rdReg & tgt);
  end
endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
  import eprom_prog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        srcAck,
  input  dpStatus_t   sts,
  output ctrlStrobe_t stb,
  output logic        busy,
  output logic        done,
  output logic        pass,
  output logic        srcReq,
  output logic        romCeN,
  output logic        romOeN,
  output logic        romDoutEn,
  output logic        vppHigh
);
  typedef enum logic [4:0] {
    S_IDLE, S_FETCH, S_PRE_RD, S_PRE_REL, S_SETUP, S_PULSE, S_HOLD, S_GAP,
    S_VER_RD, S_VER_REL, S_NEXT, S_SETTLE, S_CMP_FETCH, S_CMP_RD, S_CMP_REL, S_DONE
  } state_e;

  state_e state, nxt;
  logic   finish, finishPass;

  always_comb begin
    nxt        = state;
    stb        = '0;
    stb.tmrSel = TM_SETUP;
    finish     = 1'b0;
    finishPass = 1'b0;
    case (state)
      S_IDLE, S_DONE: if (start) begin
        stb.addrClr = 1'b1; stb.attClr = 1'b1; nxt = S_FETCH;
      end
      S_FETCH: if (srcAck) begin
        stb.tgtLoad = 1'b1; stb.tmrLoad = 1'b1; stb.tmrSel = TM_READ; nxt = S_PRE_RD;
      end
      S_PRE_RD, S_VER_RD, S_CMP_RD: if (sts.tmrZero) begin
        stb.rdCap = 1'b1; stb.tmrLoad = 1'b1; stb.tmrSel = TM_FLOAT;
        nxt = (state == S_PRE_RD) ? S_PRE_REL : (state == S_VER_RD) ? S_VER_REL : S_CMP_REL;
      end
      S_PRE_REL: if (sts.tmrZero) begin
        if (sts.rdBad)     finish = 1'b1;
        else if (sts.rdEq) nxt = S_NEXT;
        else begin stb.tmrLoad = 1'b1; nxt = S_SETUP; end
      end
      S_SETUP: if (sts.tmrZero) begin
        stb.tmrLoad = 1'b1; stb.tmrSel = TM_PULSE; stb.attInc = 1'b1; nxt = S_PULSE;
      end
      S_PULSE: if (sts.tmrZero) begin
        stb.tmrLoad = 1'b1; stb.tmrSel = TM_HOLD; nxt = S_HOLD;
      end
      S_HOLD: if (sts.tmrZero) nxt = S_GAP;
      S_GAP: begin
        stb.tmrLoad = 1'b1; stb.tmrSel = TM_READ; nxt = S_VER_RD;
      end
      S_VER_REL: if (sts.tmrZero) begin
        if (sts.rdEq)        nxt = S_NEXT;
        else if (sts.attMax) finish = 1'b1;
        else begin stb.tmrLoad = 1'b1; nxt = S_SETUP; end
      end
      S_NEXT: begin
        if (sts.lastAddr) begin
          stb.addrClr = 1'b1; stb.tmrLoad = 1'b1; nxt = S_SETTLE;
        end else begin
          stb.addrInc = 1'b1; stb.attClr = 1'b1; nxt = S_FETCH;
        end
      end
      S_SETTLE: if (sts.tmrZero) nxt = S_CMP_FETCH;
      S_CMP_FETCH: if (srcAck) begin
        stb.tgtLoad = 1'b1; stb.tmrLoad = 1'b1; stb.tmrSel = TM_READ; nxt = S_CMP_RD;
      end
      S_CMP_REL: if (sts.tmrZero) begin
        if (!sts.rdEq)        finish = 1'b1;
        else if (sts.lastAddr) begin finish = 1'b1; finishPass = 1'b1; end
        else begin stb.addrInc = 1'b1; nxt = S_CMP_FETCH; end
      end
      default: nxt = S_IDLE;
    endcase
    if (finish) nxt = S_DONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else begin
      state <= nxt;
      if (finish) begin
        done <= 1'b1;
        pass <= finishPass;
      end else if (stb.addrClr && (state == S_IDLE || state == S_DONE)) begin
        done <= 1'b0;
        pass <= 1'b0;
      end
    end
  end

  always_comb begin
    busy      = (state != S_IDLE) && (state != S_DONE);
    srcReq    = (state == S_FETCH) || (state == S_CMP_FETCH);
    romOeN    = !((state == S_PRE_RD) || (state == S_VER_RD) || (state == S_CMP_RD));
    romCeN    = !((state == S_PULSE) || (state == S_CMP_RD));
    romDoutEn = (state == S_SETUP) || (state == S_PULSE) || (state == S_HOLD);
    vppHigh   = (state inside {S_FETCH, S_PRE_RD, S_PRE_REL, S_SETUP, S_PULSE,
                               S_HOLD, S_GAP, S_VER_RD, S_VER_REL, S_NEXT});
  end
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_prog_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 250,
  parameter int PULSE_CYC  = 12500,
  parameter int HOLD_CYC   = 250,
  parameter int READ_CYC   = 19,
  parameter int FLOAT_CYC  = 17,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              srcReq,
  output logic [ADDR_W-1:0] srcAddr,
  input  logic              srcAck,
  input  logic [DATA_W-1:0] srcData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] romDout,
  output logic              romDoutEn,
  input  logic [DATA_W-1:0] romDin,
  output logic              romCeN,
  output logic              romOeN,
  output logic              vppHigh
);
  ctrlStrobe_t       stb;
  dpStatus_t         sts;
  logic [ADDR_W-1:0] addr;

  eprom_prog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .srcAck(srcAck), .sts(sts), .stb(stb),
    .busy(busy), .done(done), .pass(pass), .srcReq(srcReq), .romCeN(romCeN),
    .romOeN(romOeN), .romDoutEn(romDoutEn), .vppHigh(vppHigh)
  );

  eprom_prog_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .READ_CYC(READ_CYC), .FLOAT_CYC(FLOAT_CYC), .MAX_PULSES(MAX_PULSES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sts(sts), .addr(addr), .tgt(romDout),
    .srcData(srcData), .romDin(romDin)
  );

  assign srcAddr = addr;
  assign romAddr = addr;
endmodule

// File: rtl/eprom_prog_chk.sv
module eprom_prog_chk #(
  parameter int ADDR_W     = 15,
  parameter int PULSE_CYC  = 12500,
  parameter int MAX_PULSES = 25
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              srcReq,
  input logic              srcAck,
  input logic [ADDR_W-1:0] srcAddr,
  input logic [ADDR_W-1:0] romAddr,
  input logic              romDoutEn,
  input logic              romCeN,
  input logic              romOeN,
  input logic              vppHigh
);
  int unsigned       lowCnt, pulseCnt;
  logic              prevCeN;
  logic [ADDR_W-1:0] prevAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt   <= 0;
      pulseCnt <= 0;
      prevCeN  <= 1'b1;
      prevAddr <= '0;
    end else begin
      lowCnt   <= romCeN ? 0 : lowCnt + 1;
      prevCeN  <= romCeN;
      prevAddr <= romAddr;
      if (!vppHigh || romAddr != prevAddr) pulseCnt <= 0;
      else if (prevCeN && !romCeN)         pulseCnt <= pulseCnt + 1;
    end
  end

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    romDoutEn |-> romOeN);
  // R5
  pulse_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!romCeN && vppHigh) |-> (romDoutEn && romOeN));
  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(romCeN) && vppHigh) |-> (lowCnt == PULSE_CYC));
  // R9
  cmp_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!romCeN && !vppHigh) |-> (!romOeN && !romDoutEn));
  // R8
  attempt_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(romCeN) && vppHigh) |-> (pulseCnt < MAX_PULSES));
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq && !srcAck) |=> (srcReq && $stable(srcAddr)));
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind eprom_prog_seq eprom_prog_chk #(
  .ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC), .MAX_PULSES(MAX_PULSES)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .srcReq(srcReq), .srcAck(srcAck),
  .srcAddr(srcAddr), .romAddr(romAddr), .romDoutEn(romDoutEn), .romCeN(romCeN),
  .romOeN(romOeN), .vppHigh(vppHigh)
);

// File: tb/eprom_prog_seq_tb.sv
module eprom_prog_seq_tb;
  localparam int AW = 3, DW = 8, NB = 1 << AW;
  localparam int SC = 3, PC = 5, HC = 2, RC = 2, FC = 2, MP = 25;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic busy, done, pass, srcReq, srcAck = 1'b0, romDoutEn, romCeN, romOeN, vppHigh;
  logic [AW-1:0] srcAddr, romAddr;
  logic [DW-1:0] srcData = '0, romDout, romDin;

  logic [DW-1:0] mem [NB];
  logic [DW-1:0] img [NB];
  int need [NB];
  int pulses [NB];
  int corruptAddr = -1;
  int checks = 0, errors = 0;
  int ackCnt, cmpReads, drvErr, widthErr, setupErr, contErr, reqErr, dataErr, cmpPulseErr;
  int drvCnt = 0, lowCnt = 0;
  logic prevCeN = 1'b1, prevOeN = 1'b1;

  always #4 clk = ~clk;

  eprom_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SC), .PULSE_CYC(PC), .HOLD_CYC(HC),
    .READ_CYC(RC), .FLOAT_CYC(FC), .MAX_PULSES(MP)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .pass(pass),
    .srcReq(srcReq), .srcAddr(srcAddr), .srcAck(srcAck), .srcData(srcData),
    .romAddr(romAddr), .romDout(romDout), .romDoutEn(romDoutEn), .romDin(romDin),
    .romCeN(romCeN), .romOeN(romOeN), .vppHigh(vppHigh));

  assign romDin = !romOeN ?
    ((!vppHigh && int'(romAddr) == corruptAddr) ? (mem[romAddr] ^ 8'h01) : mem[romAddr]) : 8'hA5;

  // memory and source models, observed away from the active edge
  always @(negedge clk) begin
    if (srcReq && !srcAck) begin
      srcAck = 1'b1; srcData = img[srcAddr]; ackCnt++;
    end else srcAck = 1'b0;
    if (srcReq && srcAddr != romAddr) reqErr++;
    if (romDoutEn && romDout != img[romAddr]) dataErr++;
    if (romDoutEn && !romOeN) contErr++;
    if (vppHigh && !romCeN && prevCeN) begin
      if (drvCnt != SC) setupErr++;
      pulses[romAddr]++;
      if (pulses[romAddr] >= need[romAddr]) mem[romAddr] = mem[romAddr] & romDout;
    end
    if (!vppHigh && !romCeN && romOeN) cmpPulseErr++;
    if (!vppHigh && !romOeN && prevOeN) cmpReads++;
    if (romDoutEn) drvCnt++;
    else begin
      if (drvCnt != 0 && drvCnt != SC + PC + HC) drvErr++;
      drvCnt = 0;
    end
    if (vppHigh && !romCeN) lowCnt++;
    else begin
      if (lowCnt != 0 && lowCnt != PC) widthErr++;
      lowCnt = 0;
    end
    prevCeN = romCeN;
    prevOeN = romOeN;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic prep(input logic [DW-1:0] fill, input logic [DW-1:0] pat, input int n);
    for (int i = 0; i < NB; i++) begin
      mem[i] = fill; img[i] = pat; need[i] = n; pulses[i] = 0;
    end
    corruptAddr = -1;
    ackCnt = 0; cmpReads = 0; drvErr = 0; widthErr = 0; setupErr = 0;
    contErr = 0; reqErr = 0; dataErr = 0; cmpPulseErr = 0;
  endtask

  task automatic runAndWait(input int midStartAt);
    int cyc = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (cyc == midStartAt) start = 1'b1; else start = 1'b0;
    end
    start = 1'b0;
    check(done == 1'b1, "R11 run completes", int'(done), 1);
  endtask

  task automatic timingChecks(input string tag);
    check(setupErr == 0, {tag, " R5 setup"}, setupErr, 0);
    check(widthErr == 0, {tag, " R5 pulse width"}, widthErr, 0);
    check(drvErr == 0, {tag, " R5 hold"}, drvErr, 0);
    check(contErr == 0, {tag, " R6 contention"}, contErr, 0);
    check(reqErr == 0 && dataErr == 0, {tag, " R2 fetch"}, reqErr + dataErr, 0);
    check(cmpPulseErr == 0, {tag, " R9 no pulse"}, cmpPulseErr, 0);
  endtask

  task automatic testReset();
    check(!busy && !done && !srcReq && !romDoutEn && !vppHigh, "R1 idle low outputs",
          {busy, done, srcReq, romDoutEn, vppHigh}, 0);
    check(romCeN && romOeN, "R1 enables high", {romCeN, romOeN}, 2'b11);
  endtask

  task automatic testMixedImage();
    int expP [NB] = '{0, 1, 2, 3, 0, 1, 1, 2};
    prep(8'hFF, 8'h00, 1);
    img = '{8'hFF, 8'h00, 8'h5A, 8'hA5, 8'hFF, 8'h0F, 8'hF0, 8'h3C};
    need = '{1, 1, 2, 3, 1, 1, 1, 2};
    runAndWait(40);
    check(pass == 1'b1, "R11 pass", int'(pass), 1);
    for (int i = 0; i < NB; i++)
      check(pulses[i] == expP[i], (expP[i] == 0) ? "R4 skip" : "R7 pulses", pulses[i], expP[i]);
    check(cmpReads == NB, "R9 read-back count", cmpReads, NB);
    check(ackCnt == 2 * NB, "R11 mid-run start ignored", ackCnt, 2 * NB);
    check(!vppHigh, "R9 voltage back low", int'(vppHigh), 0);
    timingChecks("mixed");
  endtask

  task automatic testUpBit();
    prep(8'hFF, 8'h7E, 1);
    mem[3] = 8'h00; img[3] = 8'h01;
    runAndWait(-1);
    check(pass == 1'b0, "R3 fail", int'(pass), 0);
    check(romAddr == 3, "R3 address", int'(romAddr), 3);
    check(pulses[3] == 0, "R3 no pulse", pulses[3], 0);
    check(pulses[2] == 1, "R7 earlier byte", pulses[2], 1);
    check(cmpReads == 0, "R3 no read-back", cmpReads, 0);
    timingChecks("upbit");
  endtask

  task automatic testLimit(input int n, input bit expPass);
    prep(8'hFF, 8'h55, 1);
    need[2] = n;
    runAndWait(-1);
    check(pass == expPass, expPass ? "R7 limit edge pass" : "R8 fail", int'(pass), int'(expPass));
    check(pulses[2] == MP, expPass ? "R7 exact count" : "R8 capped", pulses[2], MP);
    if (!expPass) begin
      check(romAddr == 2, "R8 address", int'(romAddr), 2);
      check(pulses[3] == 0, "R8 stops", pulses[3], 0);
    end else check(cmpReads == NB, "R9 reads", cmpReads, NB);
    timingChecks("limit");
  endtask

  task automatic testReadBack();
    prep(8'hFF, 8'h33, 1);
    corruptAddr = 5;
    runAndWait(-1);
    check(pass == 1'b0, "R10 fail", int'(pass), 0);
    check(romAddr == 5, "R10 address", int'(romAddr), 5);
    check(cmpReads == 6, "R10 stop point", cmpReads, 6);
    check(pulses[7] == 1, "R7 all programmed", pulses[7], 1);
    timingChecks("readback");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    prep(8'hFF, 8'hFF, 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMixedImage();
    testUpBit();
    testLimit(30, 1'b0);
    testLimit(25, 1'b1);
    testReadBack();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule